// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Sequencer

This block is the digital control of a successive-approximation analog-to-digital converter. It has no conversion clock of its own: each rising edge of the host's serial clock moves the conversion on by one bit. A falling chip-select ends tracking, puts the sample-and-hold into hold and loads the most significant trial bit into the DAC code. Each later serial clock rising edge either sends out a lead-in zero or decides one result bit from the comparator. A decided bit goes straight to the serial data output, so the result streams out while it is being converted.

The block samples the serial clock, chip-select and shutdown pins with a local clock `clk`. The comparator input `comp_le` is read on the local cycle in which a serial clock rising edge is seen. The analog comparator, the capacitor DAC and the reference are outside the block. The serial output is given as a data bit plus an output enable, and a pad cell turns the pair into a tri-state pin. The finished code also appears on a parallel port together with a one-cycle strobe.

Top module: `sar_sclk_seq`

## Requirements
- R1: After reset the block tracks (`hold` = 0), the serial output is disabled (`dout_oe` = 0, `dout` = 0), `dac_code` is 0 and `result_valid` is 0.
- R2: A falling chip-select with `shdn_n` high enters hold (`hold` = 1), enables the output with `dout` = 0 and sets `dac_code` to the MSB trial value (only bit WIDTH-1 set; 0x800 for 12 bits).
- R3: `dout` changes only after a serial clock rising edge, or when chip-select rises or shutdown is asserted.
- R4: The serial frame after chip-select falls is LEAD_EDGES zeros (default 2) on the first rising edges, then the result MSB first: the MSB on edge LEAD_EDGES+1 (edge 3) and the LSB on edge LEAD_EDGES+WIDTH (edge 14).
- R5: When a bit is decided, the trial bit is kept if `comp_le` is 1 (DAC at or below the input) and cleared if it is 0, and the next lower bit is set as the new trial. With a comparator that reports `dac_code <= vin`, the final code equals `vin`.
- R6: On the edge that decides the LSB, `hold` returns to 0 (track) and `result_valid` pulses high for exactly one `clk` cycle with the full code on `result`.
- R7: Rising edges after the LSB, while chip-select stays low, output zeros and change neither `result` nor `dac_code`, and give no further strobe.
- R8: Raising chip-select before the LSB aborts: the block returns to track with the output disabled and gives no strobe.
- R9: While `shdn_n` is low a falling chip-select is ignored (no hold, output stays disabled, no strobe). Asserting shutdown during a conversion returns the block to track with the output disabled.
- R10: While chip-select is high the serial output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select; its falling edge starts a conversion |
| sclk | input | 1 | Serial clock; each rising edge advances the conversion |
| shdn_n | input | 1 | Active-low shutdown |
| comp_le | input | 1 | Comparator: 1 when the DAC level is at or below the held input |
| dac_code | output | WIDTH | Trial code for the capacitor DAC |
| hold | output | 1 | Sample-and-hold control, 1 = hold, 0 = track |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Serial output enable; the pin is high impedance when 0 |
| result | output | WIDTH | Last completed conversion code |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The comparator model compares `dac_code` against a chosen input code. Directed inputs of zero, full scale, mid-scale and an alternating pattern show whether each bit is kept or cleared as it should be, including the two ends of the range where a trial bit stuck high or low would show. A fixed-seed random set of input codes covers the remaining bit combinations and would expose an off-by-one in the frame position of the MSB or LSB. Frames with extra edges, chip-select raised early, and shutdown before and during a conversion separate the tail, abort and shutdown paths from a normal conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   typedef enum logic [1:0] {
      SEQ_TRACK = 2'd0,
      SEQ_CONV  = 2'd1,
      SEQ_TAIL  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/sarseq_sync_edge.sv
module sarseq_sync_edge #(
   parameter int          NBITS   = 3,
   parameter int          STAGES  = 2,
   parameter logic [NBITS-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] async_in,
   output logic [NBITS-1:0] level,
   output logic [NBITS-1:0] prev
);
   generate
      if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
         $error("sarseq_sync_edge: STAGES must be 1..4");
      end
   endgenerate

   logic [NBITS-1:0] chain [STAGES+1];

   assign chain[0] = async_in;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s+1] <= RST_VAL;
            else        chain[s+1] <= chain[s];
         end
      end
   endgenerate

   logic [NBITS-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= RST_VAL;
      else        last_q <= chain[STAGES];
   end

   assign level = chain[STAGES];
   assign prev  = last_q;
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
   parameter int WIDTH = 12,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load_msb,
   input  logic             decide,
   input  logic [IDX_W-1:0] pos,
   input  logic             comp_le,
   output logic [WIDTH-1:0] code
);
   localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (clear) begin
         code_q <= '0;
      end else if (load_msb) begin
         code_q <= MSB_ONE;
      end else if (decide) begin
         code_q[pos] <= comp_le;
         if (pos != '0) code_q[pos - 1'b1] <= 1'b1;
      end
   end

   assign code = code_q;

   // R2: a start loads exactly the top trial bit
   a_r2_msb_trial: assert property (@(posedge clk) disable iff (!rst_n)
      (load_msb && !clear) |=> (code_q == MSB_ONE));

   // R5: a deciding edge with a low comparator never leaves more bits set
   a_r5_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !load_msb && !clear && !comp_le && pos == '0)
         |=> (code_q[0] == 1'b0));
endmodule

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
   import sarseq_pkg::*;
#(
   parameter int WIDTH      = 12,
   parameter int LEAD_EDGES = 2,
   localparam int IDX_W     = $clog2(WIDTH),
   localparam int CNT_W     = $clog2(LEAD_EDGES + WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_hi,
   input  logic             cs_fall,
   input  logic             sclk_rise,
   input  logic             shdn_on,
   input  logic             comp_le,
   input  logic [WIDTH-1:0] code,
   output logic             sar_clear,
   output logic             sar_load,
   output logic             sar_decide,
   output logic [IDX_W-1:0] sar_pos,
   output logic             hold,
   output logic             dout,
   output logic             dout_oe,
   output logic [WIDTH-1:0] result,
   output logic             result_valid
);
   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             dout_q;
   logic [WIDTH-1:0] result_q;
   logic             valid_q;

   logic             force_idle;
   logic             in_lead;
   int               pos_int;

   always_comb begin
      force_idle = shdn_on || cs_hi;
      in_lead    = (int'(cnt_q) < LEAD_EDGES);
      pos_int    = WIDTH - 1 - (int'(cnt_q) - LEAD_EDGES);
      if (pos_int < 0) pos_int = 0;
      sar_pos    = pos_int[IDX_W-1:0];
      sar_clear  = force_idle;
      sar_load   = !force_idle && (st_q == SEQ_TRACK) && cs_fall;
      sar_decide = !force_idle && (st_q == SEQ_CONV) && sclk_rise && !in_lead;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_TRACK;
         cnt_q    <= '0;
         dout_q   <= 1'b0;
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (force_idle) begin
            st_q   <= SEQ_TRACK;
            cnt_q  <= '0;
            dout_q <= 1'b0;
         end else begin
            unique case (st_q)
               SEQ_TRACK: begin
                  if (cs_fall) begin
                     st_q   <= SEQ_CONV;
                     cnt_q  <= '0;
                     dout_q <= 1'b0;
                  end
               end
               SEQ_CONV: begin
                  if (sclk_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                     if (in_lead) begin
                        dout_q <= 1'b0;
                     end else begin
                        dout_q <= comp_le;
                        if (pos_int == 0) begin
                           st_q     <= SEQ_TAIL;
                           result_q <= {code[WIDTH-1:1], comp_le};
                           valid_q  <= 1'b1;
                        end
                     end
                  end
               end
               SEQ_TAIL: begin
                  if (sclk_rise) dout_q <= 1'b0;
               end
               default: st_q <= SEQ_TRACK;
            endcase
         end
      end
   end

   assign hold         = (st_q == SEQ_CONV);
   assign dout_oe      = (st_q != SEQ_TRACK);
   assign dout         = dout_q;
   assign result       = result_q;
   assign result_valid = valid_q;

   // R3: the serial bit moves only on a clock edge, a deselect or shutdown
   a_r3_dout_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_q) |-> ($past(sclk_rise) || $past(cs_hi) || $past(shdn_on)));

   // R6: completion strobe lasts one cycle and coincides with track
   a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   a_r6_track_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> !hold);

   // R7: once in the tail, the parallel result stays put
   a_r7_tail_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_TAIL && !valid_q) |-> $stable(result_q));

   // R8 / R10: a high chip-select always leaves the output disabled
   a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (!dout_oe && !hold));

   // R9: shutdown blocks a conversion
   a_r9_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_on |=> (!dout_oe && !valid_q));
endmodule

// File: rtl/sar_sclk_seq.sv
module sar_sclk_seq #(
   parameter int WIDTH       = 12,
   parameter int LEAD_EDGES  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             shdn_n,
   input  logic             comp_le,
   output logic [WIDTH-1:0] dac_code,
   output logic             hold,
   output logic             dout,
   output logic             dout_oe,
   output logic [WIDTH-1:0] result,
   output logic             result_valid
);
   generate
      if (WIDTH < 2 || WIDTH > 24) begin : g_bad_width
         $error("sar_sclk_seq: WIDTH must be 2..24");
      end
      if (LEAD_EDGES < 0 || LEAD_EDGES > 8) begin : g_bad_lead
         $error("sar_sclk_seq: LEAD_EDGES must be 0..8");
      end
   endgenerate

   // bit 0 = cs_n, bit 1 = sclk, bit 2 = shdn_n
   logic [2:0] pins_lvl, pins_prev;

   sarseq_sync_edge #(
      .NBITS  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b001)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in({shdn_n, sclk, cs_n}),
      .level   (pins_lvl),
      .prev    (pins_prev)
   );

   logic cs_hi, cs_fall, sclk_rise, shdn_on;
   assign cs_hi     = pins_lvl[0];
   assign cs_fall   = pins_prev[0] && !pins_lvl[0];
   assign sclk_rise = pins_lvl[1] && !pins_prev[1];
   assign shdn_on   = !pins_lvl[2];

   logic             sar_clear, sar_load, sar_decide;
   logic [IDX_W-1:0] sar_pos;
   logic [WIDTH-1:0] code;

   sarseq_sar #(.WIDTH(WIDTH)) u_sar (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (sar_clear),
      .load_msb(sar_load),
      .decide  (sar_decide),
      .pos     (sar_pos),
      .comp_le (comp_le),
      .code    (code)
   );

   sarseq_ctrl #(.WIDTH(WIDTH), .LEAD_EDGES(LEAD_EDGES)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_hi       (cs_hi),
      .cs_fall     (cs_fall),
      .sclk_rise   (sclk_rise),
      .shdn_on     (shdn_on),
      .comp_le     (comp_le),
      .code        (code),
      .sar_clear   (sar_clear),
      .sar_load    (sar_load),
      .sar_decide  (sar_decide),
      .sar_pos     (sar_pos),
      .hold        (hold),
      .dout        (dout),
      .dout_oe     (dout_oe),
      .result      (result),
      .result_valid(result_valid)
   );

   assign dac_code = code;
endmodule

// File: tb/sar_sclk_seq_test.sv
module sar_sclk_seq_test;
   localparam int W    = 12;
   localparam int LEAD = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         shdn_n = 1'b1;
   logic [W-1:0] vin = '0;
   logic         comp_le;
   logic [W-1:0] dac_code, result;
   logic         hold, dout, dout_oe, result_valid;

   int n_checks = 0;
   int n_fail   = 0;
   int strobes  = 0;
   logic [W-1:0] strobe_val = '0;

   always #2.5 clk = ~clk;

   assign comp_le = (dac_code <= vin);

   sar_sclk_seq #(.WIDTH(W), .LEAD_EDGES(LEAD), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .shdn_n(shdn_n),
      .comp_le(comp_le), .dac_code(dac_code), .hold(hold), .dout(dout),
      .dout_oe(dout_oe), .result(result), .result_valid(result_valid)
   );

   always @(negedge clk) begin
      if (result_valid) begin
         strobes    <= strobes + 1;
         strobe_val <= result;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_pulse();
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
   endtask

   function automatic bit exp_bit(input logic [W-1:0] v, input int edge_no);
      if (edge_no <= LEAD || edge_no > LEAD + W) return 1'b0;
      return v[W - 1 - (edge_no - LEAD - 1)];
   endfunction

   task automatic full_conv(input logic [W-1:0] v, input int edges);
      int s0;
      int bad;
      logic [W-1:0] got;
      vin = v;
      s0  = strobes;
      bad = 0;
      got = '0;
      cs_n = 1'b0;
      wait_clk(6);
      check(hold && dout_oe && !dout && dac_code == 12'h800, "R2 start",
            {hold, dout_oe, dout}, 3'b110);
      for (int k = 1; k <= edges; k++) begin
         sclk_pulse();
         if (dout !== exp_bit(v, k)) bad++;
         if (k > LEAD && k <= LEAD + W) got[W - 1 - (k - LEAD - 1)] = dout;
         if (k == LEAD + W)
            check(!hold && dout_oe, "R6 track after LSB", {hold, dout_oe}, 2'b01);
      end
      check(got == v, "R4 frame bits", got, v);
      check(bad == 0, "R7 frame and tail zeros", bad, 0);
      check(strobes == s0 + 1, "R6 one strobe", strobes - s0, 1);
      check(strobe_val == v && result == v, "R5 result code", result, v);
      check(dac_code == v, "R7 code held in tail", dac_code, v);
      cs_n = 1'b1;
      wait_clk(6);
      check(!dout_oe && !hold && !dout, "R10 deselected", {dout_oe, hold}, 0);
   endtask

   initial begin : watchdog
      #400000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      int s0;
      void'($urandom(32'h5A17));
      wait_clk(3);
      check(!hold && !dout_oe && !dout && dac_code == 0 && !result_valid,
            "R1 reset state", {hold, dout_oe, dout}, 0);
      rst_n = 1'b1;
      wait_clk(4);
      check(!dout_oe, "R10 idle output off", dout_oe, 0);

      full_conv(12'h000, LEAD + W);
      full_conv(12'hFFF, LEAD + W + 1);
      full_conv(12'h800, LEAD + W + 1);
      full_conv(12'h555, LEAD + W + 6);
      full_conv(12'hAAA, LEAD + W + 1);
      for (int i = 0; i < 8; i++) full_conv(12'($urandom()), LEAD + W + 1 + (i % 3));

      // R8: abort in mid-conversion
      vin = 12'h3C5;
      s0 = strobes;
      cs_n = 1'b0;
      wait_clk(6);
      for (int k = 0; k < 8; k++) sclk_pulse();
      cs_n = 1'b1;
      wait_clk(6);
      check(!dout_oe && !hold && strobes == s0, "R8 abort", {dout_oe, hold}, 0);
      full_conv(12'h3C5, LEAD + W + 1);

      // R9: shutdown blocks a start
      shdn_n = 1'b0;
      wait_clk(6);
      s0 = strobes;
      cs_n = 1'b0;
      wait_clk(6);
      check(!dout_oe && !hold, "R9 start ignored in shutdown", {dout_oe, hold}, 0);
      for (int k = 0; k < LEAD + W + 1; k++) sclk_pulse();
      check(!dout_oe && strobes == s0, "R9 no conversion in shutdown", strobes - s0, 0);
      cs_n = 1'b1;
      shdn_n = 1'b1;
      wait_clk(6);

      // R9: shutdown during a conversion
      cs_n = 1'b0;
      wait_clk(6);
      for (int k = 0; k < 6; k++) sclk_pulse();
      shdn_n = 1'b0;
      wait_clk(6);
      check(!dout_oe && !hold, "R9 shutdown mid conversion", {dout_oe, hold}, 0);
      shdn_n = 1'b1;
      for (int k = 0; k < 4; k++) sclk_pulse();
      check(!dout_oe && strobes == s0, "R9 stays idle without new start",
            {dout_oe, hold}, 0);
      cs_n = 1'b1;
      wait_clk(6);
      full_conv(12'h001, LEAD + W + 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule